// File: doc/BRIEF.md
# ATA Status Error Classifier

This block sorts the outcome of an ATA or packet-command transaction into exactly one exception category. On each evaluation request it samples the device status bits (busy, ready, data request, error), the device error bits (interface CRC, aborted, uncorrectable, ID not found), the DMA engine's error flag, a timeout strobe with a command-finished flag, the command kind and the current command phase. One cycle later it presents a one-hot category together with a one-cycle valid strobe.

The same status value can mean different things at different points of a command. The block therefore qualifies every bit pattern with the phase. An error bit seen while the command packet is still being written is a protocol fault. The same bit seen after the packet has been taken is a check condition. Seen on an ordinary command, it is a device error. Where several conditions hold at once, a fixed priority picks one. A host-side error handler uses the result to choose its recovery path.

Top module: `ata_err_classifier`

## Requirements
- R1: When `eval_req` is high at a clock edge, `cat_valid` is high for exactly the following cycle and `cat` then has exactly one bit set. At every other time, including reset, `cat_valid` is low and `cat` is zero. The bits of `cat` are: 0 protocol violation, 1 system-bus error, 2 bus transfer error, 3 check condition, 4 media error, 5 address error, 6 other device error, 7 late completion, 8 unknown timeout, 9 clean.
- R2: In phase code 0 (issue), any status other than busy clear, ready set and data request clear is a protocol violation.
- R3: In phase code 1 (PIO data), busy clear with data request clear is a protocol violation.
- R4: In phase code 4 (completion), data request set is a protocol violation.
- R5: For a packet command in phase code 2 (packet transfer) with busy clear and error set: if aborted is clear, the result is a protocol violation; if aborted is set, the command is unsupported and the result is other device error.
- R6: For a packet command in phase code 1, 3 (after last packet byte) or 4, busy clear with error set is a check condition, whatever the aborted bit.
- R7: For an ordinary command in phase codes 1 to 4, busy clear with error set is a device error. Interface CRC gives bus transfer error; otherwise uncorrectable gives media error; otherwise ID not found gives address error; otherwise the result is other device error.
- R8: A set DMA error flag gives system-bus error.
- R9: A timeout with the command finished gives late completion. A timeout with the command not finished gives unknown timeout.
- R10: Priority, from highest to lowest: protocol violation, system-bus, bus transfer, check condition, media, address, other device, late completion, unknown timeout. When none applies, the result is clean.
- R11: Phase codes 5 to 7 are reserved and are always classified as a protocol violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_req | input | 1 | Evaluation request, one per cycle |
| st_bsy | input | 1 | Status: busy |
| st_drdy | input | 1 | Status: device ready |
| st_drq | input | 1 | Status: data request |
| st_err | input | 1 | Status: error |
| er_icrc | input | 1 | Error: interface CRC |
| er_abrt | input | 1 | Error: command aborted |
| er_unc | input | 1 | Error: uncorrectable data |
| er_idnf | input | 1 | Error: ID not found |
| dma_err | input | 1 | DMA engine status error |
| tmo | input | 1 | Command timeout strobe |
| cmd_done | input | 1 | Command found finished |
| pkt_cmd | input | 1 | 1 = packet command, 0 = ordinary command |
| phase | input | 3 | Command phase code (0..4, 5..7 reserved) |
| cat | output | 10 | One-hot category |
| cat_valid | output | 1 | Category valid strobe |

## Verification
The bench uses the default package constants: a 3-bit phase code and ten categories. At that size the whole input space has only 15 bits, so the bench applies every combination once with evaluation requested on every cycle. This covers all eight phase codes, including the reserved ones, and every overlap that the priority order must resolve. A second pass thins out the evaluation requests so that the zero output and the strobe falling between results are exercised.

// File: rtl/ata_cls_pkg.sv
package ata_cls_pkg;
  localparam int PHASE_W = 3;
  localparam int NCAT    = 10;

  localparam logic [PHASE_W-1:0] PH_ISSUE = 3'd0;
  localparam logic [PHASE_W-1:0] PH_PIO   = 3'd1;
  localparam logic [PHASE_W-1:0] PH_CDB   = 3'd2;
  localparam logic [PHASE_W-1:0] PH_POST  = 3'd3;
  localparam logic [PHASE_W-1:0] PH_DONE  = 3'd4;

  // category index = priority rank (0 highest)
  localparam int C_PROTO  = 0;
  localparam int C_SYSBUS = 1;
  localparam int C_XFER   = 2;
  localparam int C_CHECK  = 3;
  localparam int C_MEDIA  = 4;
  localparam int C_ADDR   = 5;
  localparam int C_OTHER  = 6;
  localparam int C_LATE   = 7;
  localparam int C_HUNG   = 8;
  localparam int C_CLEAN  = 9;
endpackage

// File: rtl/ata_cls_proto.sv
module ata_cls_proto
  import ata_cls_pkg::*;
(
  input  logic               bsy,
  input  logic               drdy,
  input  logic               drq,
  input  logic               err,
  input  logic               abrt,
  input  logic               pkt,
  input  logic [PHASE_W-1:0] phase,
  output logic               viol
);
  always_comb begin
    unique case (phase)
      PH_ISSUE: viol = bsy | ~drdy | drq;
      PH_PIO:   viol = ~bsy & ~drq;
      PH_CDB:   viol = pkt & ~bsy & err & ~abrt;
      PH_POST:  viol = 1'b0;
      PH_DONE:  viol = drq;
      default:  viol = 1'b1;
    endcase
  end
endmodule

// File: rtl/ata_cls_dev.sv
module ata_cls_dev
  import ata_cls_pkg::*;
(
  input  logic               bsy,
  input  logic               err,
  input  logic               icrc,
  input  logic               abrt,
  input  logic               unc,
  input  logic               idnf,
  input  logic               pkt,
  input  logic [PHASE_W-1:0] phase,
  output logic               xfer,
  output logic               check,
  output logic               media,
  output logic               addr,
  output logic               other
);
  logic fail_seen;
  logic in_cmd;
  logic ata_fail;
  logic pkt_unsup;

  always_comb begin
    fail_seen = ~bsy & err;
    in_cmd    = (phase != PH_ISSUE) && (phase <= PH_DONE);
    ata_fail  = ~pkt & fail_seen & in_cmd;
    pkt_unsup = pkt & fail_seen & abrt & (phase == PH_CDB);
    check     = pkt & fail_seen &
                ((phase == PH_PIO) || (phase == PH_POST) || (phase == PH_DONE));
    // subclass ordering is left to the priority chain
    xfer      = ata_fail & icrc;
    media     = ata_fail & unc;
    addr      = ata_fail & idnf;
    other     = ata_fail | pkt_unsup;
  end
endmodule

// File: rtl/ata_cls_prio.sv
module ata_cls_prio #(
  parameter int N = 10
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  for (genvar i = 0; i < N; i++) begin : g_rank
    if (i == 0) begin : g_top
      assign grant[i] = req[i];
    end else begin : g_lower
      assign grant[i] = req[i] & ~(|req[i-1:0]);
    end
  end
endmodule

// File: rtl/ata_err_classifier.sv
module ata_err_classifier
  import ata_cls_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eval_req,
  input  logic               st_bsy,
  input  logic               st_drdy,
  input  logic               st_drq,
  input  logic               st_err,
  input  logic               er_icrc,
  input  logic               er_abrt,
  input  logic               er_unc,
  input  logic               er_idnf,
  input  logic               dma_err,
  input  logic               tmo,
  input  logic               cmd_done,
  input  logic               pkt_cmd,
  input  logic [PHASE_W-1:0] phase,
  output logic [NCAT-1:0]    cat,
  output logic               cat_valid
);
  // reset: asserted asynchronously, released through a synchroniser
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  logic proto_viol;
  logic d_xfer, d_check, d_media, d_addr, d_other;

  ata_cls_proto u_proto (
    .bsy(st_bsy), .drdy(st_drdy), .drq(st_drq), .err(st_err),
    .abrt(er_abrt), .pkt(pkt_cmd), .phase(phase), .viol(proto_viol)
  );

  ata_cls_dev u_dev (
    .bsy(st_bsy), .err(st_err), .icrc(er_icrc), .abrt(er_abrt),
    .unc(er_unc), .idnf(er_idnf), .pkt(pkt_cmd), .phase(phase),
    .xfer(d_xfer), .check(d_check), .media(d_media), .addr(d_addr),
    .other(d_other)
  );

  logic [NCAT-1:0] req_vec;
  logic [NCAT-1:0] grant_vec;

  always_comb begin
    req_vec          = '0;
    req_vec[C_PROTO] = proto_viol;
    req_vec[C_SYSBUS]= dma_err;
    req_vec[C_XFER]  = d_xfer;
    req_vec[C_CHECK] = d_check;
    req_vec[C_MEDIA] = d_media;
    req_vec[C_ADDR]  = d_addr;
    req_vec[C_OTHER] = d_other;
    req_vec[C_LATE]  = tmo & cmd_done;
    req_vec[C_HUNG]  = tmo & ~cmd_done;
    req_vec[C_CLEAN] = 1'b1;
  end

  ata_cls_prio #(.N(NCAT)) u_prio (.req(req_vec), .grant(grant_vec));

  // next-state
  logic [NCAT-1:0] cat_nxt;
  logic            valid_nxt;

  always_comb begin
    valid_nxt = eval_req;
    cat_nxt   = eval_req ? grant_vec : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cat       <= '0;
      cat_valid <= 1'b0;
    end else begin
      cat       <= cat_nxt;
      cat_valid <= valid_nxt;
    end
  end

  a_r1_onehot_when_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cat_valid |-> $countones(cat) == 1);
  a_r1_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cat_valid |-> cat == '0);
  a_r1_strobe_follows_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eval_req |=> cat_valid);
  a_r1_strobe_drops: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !eval_req |=> !cat_valid);
  a_r2_busy_at_issue: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eval_req && phase == PH_ISSUE && st_bsy) |=> cat[C_PROTO]);
  a_r8_dma_flag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eval_req && dma_err && !proto_viol) |=> cat[C_SYSBUS]);
  a_r11_reserved_phase: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eval_req && phase > PH_DONE) |=> cat[C_PROTO]);
  a_r10_quiet_issue_clean: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eval_req && phase == PH_ISSUE && !st_bsy && st_drdy && !st_drq &&
     !dma_err && !tmo) |=> cat[C_CLEAN]);
endmodule

// File: tb/tb_ata_err_classifier.sv
module tb_ata_err_classifier;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       eval_req;
  logic [14:0] v;
  logic [9:0] cat;
  logic       cat_valid;

  int tests = 0;
  int fails = 0;

  logic       exp_valid;
  logic [9:0] exp_cat;
  string      exp_tag;

  always #4 clk = ~clk;

  ata_err_classifier dut (
    .clk(clk), .rst_n(rst_n), .eval_req(eval_req),
    .st_bsy(v[4]), .st_drdy(v[5]), .st_drq(v[6]), .st_err(v[7]),
    .er_icrc(v[8]), .er_abrt(v[9]), .er_unc(v[10]), .er_idnf(v[11]),
    .dma_err(v[12]), .tmo(v[13]), .cmd_done(v[14]), .pkt_cmd(v[3]),
    .phase(v[2:0]), .cat(cat), .cat_valid(cat_valid)
  );

  // behavioural reference: walk the categories in priority order
  function automatic int ref_idx(input logic [14:0] x, output string tag);
    int ph = int'(x[2:0]);
    bit pkt = x[3], bsy = x[4], rdy = x[5], drq = x[6], er = x[7];
    bit crc = x[8], ab = x[9], unc = x[10], idn = x[11];
    bit dma = x[12], to = x[13], fin = x[14];
    bit fault = !bsy && er;
    if (ph > 4)                           begin tag = "R11"; return 0; end
    if (ph == 0 && !(!bsy && rdy && !drq)) begin tag = "R2"; return 0; end
    if (ph == 1 && !bsy && !drq)          begin tag = "R3";  return 0; end
    if (ph == 4 && drq)                   begin tag = "R4";  return 0; end
    if (ph == 2 && pkt && fault && !ab)   begin tag = "R5";  return 0; end
    if (dma)                              begin tag = "R8";  return 1; end
    if (!pkt && ph != 0 && fault) begin
      tag = "R7";
      if (crc) return 2;
      if (unc) return 4;
      if (idn) return 5;
      return 6;
    end
    if (pkt && fault && (ph == 1 || ph == 3 || ph == 4)) begin tag = "R6"; return 3; end
    if (pkt && fault && ph == 2)          begin tag = "R5";  return 6; end
    if (to)                               begin tag = "R9";  return fin ? 7 : 8; end
    tag = "R10";
    return 9;
  endfunction

  task automatic check_out();
    tests++;
    if (cat_valid !== exp_valid || cat !== exp_cat) begin
      fails++;
      $display("FAIL %s: valid=%b cat=%b expected valid=%b cat=%b",
               exp_tag, cat_valid, cat, exp_valid, exp_cat);
    end
  endtask

  // one cycle: check previous result, then drive new inputs
  task automatic step(input logic ev, input logic [14:0] x);
    string t;
    int    k;
    @(negedge clk);
    check_out();
    eval_req = ev;
    v        = x;
    if (ev) begin
      k = ref_idx(x, t);
      exp_valid = 1'b1;
      exp_cat   = 10'(1) << k;
      exp_tag   = t;
    end else begin
      exp_valid = 1'b0;
      exp_cat   = '0;
      exp_tag   = "R1";
    end
  endtask

  initial begin : watchdog
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    eval_req  = 1'b0;
    v         = '0;
    exp_valid = 1'b0;
    exp_cat   = '0;
    exp_tag   = "R1";
    repeat (3) @(negedge clk);
    check_out();                 // R1 reset state
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, '0);

    // directed corner cases
    step(1'b1, 15'b000_0000_0010_0000);   // R10 clean issue
    step(1'b1, 15'b000_0000_1000_1010);   // R5 packet transfer, error, no abort
    step(1'b1, 15'b000_0010_1000_1010);   // R5 unsupported packet
    step(1'b1, 15'b000_0010_1100_1011);   // R6 check with abort
    step(1'b1, 15'b000_1111_1000_0100);   // R7 crc wins over unc/idnf
    step(1'b1, 15'b001_0000_0100_0100);   // R4 drq at completion vs dma
    step(1'b1, 15'b110_0000_0100_0100);   // R4 drq at completion vs timeout
    step(1'b1, 15'b110_0000_0000_0011);   // R9 late completion
    step(1'b1, 15'b010_0000_0000_0011);   // R9 unknown timeout
    step(1'b1, 15'b000_0000_0000_0110);   // R11 reserved phase
    step(1'b0, 15'b000_0000_0000_0110);   // R1 no request

    // exhaustive sweep, evaluation every cycle (R2..R11)
    for (int i = 0; i < 32768; i++) step(1'b1, 15'(i));
    // thinned requests (R1)
    for (int i = 0; i < 6000; i++) step((i % 3) != 0, 15'(i * 7 + 13));
    step(1'b0, '0);
    step(1'b0, '0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule